// File: doc/BRIEF.md
# Triple-Buffer Frame Capture Selector

This block sits beside a video writer that fills three frame buffers in memory in the fixed rotation 0, 1, 2, 0, ... On every periodic frame tick it looks at the writer's Gray-coded buffer pointer. It decides whether this frame is one to capture. If it is, it issues a one-cycle copy request to a downstream copy engine. The request carries the start address and byte length of the most recently finished buffer, never the buffer under write.

Only one tick in every `DECIM` ticks is a capture tick (six by default, so a 60 Hz source yields 10 captures per second). The first tick after reset is always a capture tick. The copy engine reports a busy level back to the block. A capture tick that finds the engine busy is dropped and counted in a saturating counter. An illegal pointer code raises an error pulse and blocks the request. Destination addressing and the data movement itself belong to the copy engine.

Top module: `frame_capture_sel`

## Requirements
- R1: After reset, `req_o` and `gray_err_o` are 0, `overrun_cnt_o` is 0, and the decimation phase is cleared, so the first tick after reset is a capture tick.
- R2: The pointer `wr_ptr_gray_i` is decoded as Gray code: 2'b00 is buffer 0, 2'b01 is buffer 1, and 2'b11 is buffer 2.
- R3: The selected source buffer is the one before the buffer being written: writing 1 selects 0, writing 2 selects 1, and writing 0 selects 2. `req_addr_o` equals `src_base_i + sel * frame_stride_i`.
- R4: Counting ticks from reset as 0, 1, 2, ..., a tick is a capture tick exactly when its count is a multiple of `DECIM` (default 6).
- R5: `req_len_o` equals the `frame_bytes_i` value present on the capture tick (default frame 1280x720x3 = 2,764,800 bytes).
- R6: On any tick with pointer code 2'b10, `gray_err_o` pulses for one cycle and no request is issued; the decimation phase still advances.
- R7: A legal capture tick with `copy_busy_i` high issues no request and increments `overrun_cnt_o`. The counter saturates at its maximum. The decimation phase still advances.
- R8: A granted request appears as `req_o` high for exactly one cycle, in the cycle after the tick is sampled. `req_addr_o` and `req_len_o` are valid in that same cycle.
- R9: Cycles without a tick produce no request, no error pulse, and no change to the decimation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Frame-period tick, one cycle wide |
| wr_ptr_gray_i | input | 2 | Gray-coded index of the buffer being written |
| src_base_i | input | AW | Address of buffer 0 |
| frame_stride_i | input | AW | Address distance between buffers |
| frame_bytes_i | input | LW | Bytes per frame copy |
| copy_busy_i | input | 1 | Copy engine still moving the previous frame |
| req_o | output | 1 | Copy request strobe |
| req_addr_o | output | AW | Source address of the frame to copy |
| req_len_o | output | LW | Copy length in bytes |
| gray_err_o | output | 1 | Illegal pointer code seen on a tick |
| overrun_cnt_o | output | OVR_W | Saturating count of requests dropped while busy |

## Verification
Several properties are checked on every cycle. A request is only issued one cycle after a tick, and never after a busy or illegal pointer sample. An error pulse never coincides with a request. The decimation phase stays in range and holds between ticks. The overrun count only steps up by one and holds at its ceiling. The exact capture cadence, the previous-buffer choice with wraparound, the computed addresses and lengths, and saturation reached through real dropped requests can only be shown by the bench's scenarios. The bench compares each of these against a tick-count model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef logic [1:0] buf_idx_t;

  localparam int unsigned NUM_BUF = 3;

  localparam logic [1:0] GRAY_B0  = 2'b00;
  localparam logic [1:0] GRAY_B1  = 2'b01;
  localparam logic [1:0] GRAY_B2  = 2'b11;
  localparam logic [1:0] GRAY_BAD = 2'b10;
endpackage

// File: rtl/fcs_gray_decode.sv
module fcs_gray_decode
  import fcs_pkg::*;
(
  input  logic [1:0] gray_i,
  output buf_idx_t   idx_o,
  output buf_idx_t   prev_idx_o,
  output logic       valid_o
);
  always_comb begin
    valid_o = 1'b1;
    unique case (gray_i)
      GRAY_B0: idx_o = 2'd0;
      GRAY_B1: idx_o = 2'd1;
      GRAY_B2: idx_o = 2'd2;
      default: begin
        idx_o   = 2'd0;
        valid_o = 1'b0;
      end
    endcase
  end

  // previous buffer in rotation, wrapping 0 -> last
  always_comb begin
    if (idx_o == 2'd0) prev_idx_o = buf_idx_t'(NUM_BUF - 1);
    else               prev_idx_o = idx_o - 2'd1;
  end
endmodule

// File: rtl/fcs_decimator.sv
module fcs_decimator #(
  parameter int unsigned RATIO = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic capture_o
);
  generate
    if (RATIO > 1) begin : g_count
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end

      assign capture_o = tick_i && (cnt_q == '0);

      AST_DECIM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);  // R4
      AST_DECIM_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_i |=> $stable(cnt_q));  // R9
    end else begin : g_pass
      assign capture_o = tick_i;
    end
  endgenerate
endmodule

// File: rtl/fcs_sat_counter.sv
module fcs_sat_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_OVR_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '1));  // R7
  AST_OVR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1));  // R7
endmodule

// File: rtl/frame_capture_sel.sv
module frame_capture_sel
  import fcs_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned LW    = 24,
  parameter int unsigned DECIM = 6,
  parameter int unsigned OVR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [1:0]       wr_ptr_gray_i,
  input  logic [AW-1:0]    src_base_i,
  input  logic [AW-1:0]    frame_stride_i,
  input  logic [LW-1:0]    frame_bytes_i,
  input  logic             copy_busy_i,
  output logic             req_o,
  output logic [AW-1:0]    req_addr_o,
  output logic [LW-1:0]    req_len_o,
  output logic             gray_err_o,
  output logic [OVR_W-1:0] overrun_cnt_o
);
  buf_idx_t wr_idx, src_idx;
  logic     ptr_ok, capture, grant, overrun;
  logic [AW-1:0] src_addr;

  fcs_gray_decode i_dec (
    .gray_i     (wr_ptr_gray_i),
    .idx_o      (wr_idx),
    .prev_idx_o (src_idx),
    .valid_o    (ptr_ok)
  );

  fcs_decimator #(.RATIO(DECIM)) i_decim (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .capture_o (capture)
  );

  assign grant   = capture && ptr_ok && !copy_busy_i;
  assign overrun = capture && ptr_ok && copy_busy_i;

  fcs_sat_counter #(.W(OVR_W)) i_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (overrun),
    .cnt_o  (overrun_cnt_o)
  );

  // index 0..2 times stride without a multiplier
  always_comb begin
    unique case (src_idx)
      2'd1:    src_addr = src_base_i + frame_stride_i;
      2'd2:    src_addr = src_base_i + (frame_stride_i << 1);
      default: src_addr = src_base_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      gray_err_o <= 1'b0;
      req_addr_o <= '0;
      req_len_o  <= '0;
    end else begin
      req_o      <= grant;
      gray_err_o <= tick_i && !ptr_ok;
      if (grant) begin
        req_addr_o <= src_addr;
        req_len_o  <= frame_bytes_i;
      end
    end
  end

  AST_REQ_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $past(tick_i));  // R8
  AST_REQ_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> !$past(copy_busy_i));  // R7
  AST_REQ_LEGAL_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> ($past(wr_ptr_gray_i) != GRAY_BAD));  // R6
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gray_err_o |-> !req_o);  // R6
  AST_QUIET_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> (!req_o && !gray_err_o));  // R9
  AST_SRC_NOT_WRITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ok |-> (src_idx != wr_idx && src_idx < 2'd3));  // R3
endmodule

// File: tb/test_frame_capture_sel.sv
`timescale 1ns/1ps
module test_frame_capture_sel;
  localparam int unsigned AW = 32, LW = 24, DECIM = 6, OVR_W = 3;
  localparam logic [AW-1:0] BASE   = 32'h0100_0000;
  localparam logic [AW-1:0] STRIDE = 32'h002A_3000;
  localparam logic [LW-1:0] FLEN   = 24'd2764800;

  logic clk = 0, rst_n = 0, tick = 0, busy = 0;
  logic [1:0] gray = 2'b00;
  logic [AW-1:0] base = BASE, stride = STRIDE;
  logic [LW-1:0] flen = FLEN;
  logic req, err;
  logic [AW-1:0] raddr;
  logic [LW-1:0] rlen;
  logic [OVR_W-1:0] ovr;

  int total = 0, bad = 0, tick_n = 0, exp_ovr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frame_capture_sel #(.AW(AW), .LW(LW), .DECIM(DECIM), .OVR_W(OVR_W)) i_frame_capture_sel (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_ptr_gray_i(gray),
    .src_base_i(base), .frame_stride_i(stride), .frame_bytes_i(flen),
    .copy_busy_i(busy), .req_o(req), .req_addr_o(raddr), .req_len_o(rlen),
    .gray_err_o(err), .overrun_cnt_o(ovr)
  );

  task automatic chk(string rq, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // R2/R3 model: writing 0->src 2, 1->0, 2->1
  function automatic logic [AW-1:0] exp_addr(logic [1:0] g);
    case (g)
      2'b00:   return base + 2 * stride;
      2'b01:   return base;
      default: return base + stride;
    endcase
  endfunction

  task automatic do_tick(logic [1:0] g, logic b);
    bit cap, legal, ereq;
    cap   = (tick_n % DECIM) == 0;
    legal = (g != 2'b10);
    ereq  = cap && legal && !b;
    tick_n++;
    if (cap && legal && b && exp_ovr < 7) exp_ovr++;
    @(negedge clk);
    tick = 1; gray = g; busy = b;
    @(negedge clk);
    tick = 0; busy = 0;
    chk("R4/R8 req", req, ereq);
    chk("R6 err", err, !legal);
    chk("R7 overrun", ovr, exp_ovr);
    if (ereq) begin
      chk("R3 addr", raddr, exp_addr(g));
      chk("R5 len", rlen, flen);
    end
    @(negedge clk);
    chk("R8/R9 req pulse", req, 0);
    chk("R9 err quiet", err, 0);
  endtask

  task automatic t_reset();
    chk("R1 req", req, 0);
    chk("R1 err", err, 0);
    chk("R1 overrun", ovr, 0);
  endtask

  task automatic t_first_capture();
    do_tick(2'b01, 0);  // R1 first tick captures, R3 selects 0
  endtask

  task automatic t_cadence();
    for (int i = 0; i < 5; i++) do_tick(2'b11, 0);  // R4 skipped ticks
    do_tick(2'b11, 0);  // R3 writing 2 selects 1
    for (int i = 0; i < 5; i++) do_tick(2'b00, 0);
    do_tick(2'b00, 0);  // R3 wrap
    repeat (10) @(negedge clk);  // R9 idle gap does not shift phase
    for (int i = 0; i < 5; i++) do_tick(2'b01, 0);
    do_tick(2'b01, 0);
  endtask

  task automatic t_illegal();
    for (int i = 0; i < 5; i++) do_tick(2'b01, 0);
    do_tick(2'b10, 0);  // R6 on capture tick
    do_tick(2'b10, 0);  // R6 on other tick
    for (int i = 0; i < 4; i++) do_tick(2'b11, 0);
    do_tick(2'b11, 0);  // next capture still on cadence
  endtask

  task automatic t_length();
    for (int i = 0; i < 5; i++) do_tick(2'b00, 0);
    flen = 24'd1234;
    do_tick(2'b00, 0);  // R5
    flen = FLEN;
  endtask

  task automatic t_overrun();
    for (int k = 0; k < 10; k++) begin
      for (int i = 0; i < 5; i++) do_tick(2'b01, 1);  // busy off-capture ignored
      do_tick(2'b01, 1);  // R7 dropped
    end
    for (int i = 0; i < 5; i++) do_tick(2'b11, 0);
    do_tick(2'b11, 0);  // R7 capture resumes, count held at 7
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_first_capture();
    t_cadence();
    t_illegal();
    t_length();
    t_overrun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule